// File: doc/BRIEF.md
# I2C Slave Masked Address Matcher

This block is the address-recognition front end of an I2C slave. It watches already-synchronised SCL and SDA levels, sampled on the system clock. It detects START, repeated START and STOP conditions. It shifts in the address byte, or both address bytes in 10-bit mode, and compares what it receives with a programmable own address. A programmable mask turns selected address bits into don't-care bits, so one slave can answer to a whole group of addresses.

When the address matches, the block pulls SDA low for the acknowledge clock. It copies the received address byte into a buffer and emits a one-cycle interrupt pulse. Because several addresses can match under a mask, software reads the buffer to learn which one was used. When the address does not match, the block stays silent and ignores the bus until the next START. A mode input chooses 7-bit or 10-bit addressing. The SDA output is an open-drain enable: 1 means pull the line low.

Top module: `i2c_addr_match`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sda_pull_o` = 0, `irq_o` = 0 and `rx_addr_o` = 8'h00.
- R2: With `ten_bit_i` = 0, the first byte after START is ACKed exactly when its bits [7:1] equal `own_lo_i[7:1]` on every bit that is not masked. `mask_i[k]` masks byte bit k+1 for k = 0..4. Bits 7 and 6 are always compared. Bit 0, the R/W bit, is never compared.
- R3: With `ten_bit_i` = 0, `own_lo_i` = 8'hA0 and `mask_i` = 5'b00111, the set of ACKed write bytes is exactly 8'hA0, A2, A4, A6, A8, AA, AC and AE.
- R4: With `ten_bit_i` = 1, the first byte is ACKed exactly when it equals {5'b11110, `own_hi_i`, 1'b0}. The mask has no effect on this byte.
- R5: With `ten_bit_i` = 1, after the first ACK the second byte is ACKed exactly when it equals `own_lo_i` on every unmasked bit. `mask_i[4:1]` masks byte bits [5:2], `mask_i[0]` masks byte bits [1:0] together, and bits 7 and 6 are always compared.
- R6: With `ten_bit_i` = 1, `own_hi_i` = 2'b01, `own_lo_i` = 8'hA0 and `mask_i` = 5'b00111, the ACKed second bytes are exactly 8'hA0 through 8'hAF.
- R7: Data bits are sampled on SCL rising edges. `sda_pull_o` rises while SCL is low after the eighth falling edge, stays high through the ninth SCL high phase, and falls within two clock cycles of the ninth falling edge. It changes only while SCL was low on the previous cycle.
- R8: After the final ACK (the only ACK in 7-bit mode, the second ACK in 10-bit mode), `irq_o` pulses for exactly one cycle on the cycle the ACK is released. The first ACK in 10-bit mode raises no pulse. On that same cycle `rx_addr_o` takes the received byte: the whole byte in 7-bit mode, the second byte in 10-bit mode. `rx_addr_o` does not change at any other time.
- R9: On a mismatch the block gives no ACK and no interrupt, and it ACKs no further byte until the next START.
- R10: A repeated START, with no STOP before it, restarts address reception from the first byte. After a STOP the block ACKs nothing until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_hi_i | input | 2 | Own address bits [9:8] (10-bit mode) |
| own_lo_i | input | 8 | Own address byte: bits [7:1] in 7-bit mode, low byte in 10-bit mode |
| mask_i | input | 5 | Don't-care mask; mapping depends on the mode (R2, R5) |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| irq_o | output | 1 | One-cycle pulse on an accepted address |
| rx_addr_o | output | 8 | Last accepted address byte |

## Verification
The assertions watch, on every cycle, that the acknowledge pull changes only while SCL was low and that the interrupt is a single-cycle pulse coinciding with the release of the pull. They also check that the address buffer updates only together with the interrupt, and that the outputs are idle just after reset. Whether a given address is accepted under a given mask and mode can only be shown by the bench scenarios. These are the full sweeps of the two worked mask cases, random own-address and mask combinations, and 10-bit header variants. The same applies to recovery through repeated START and STOP and to silence after a mismatch.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

    localparam int BYTE_W = 8;
    localparam int MASK_W = 5;
    localparam int HI_W   = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [4:0] TEN_TAG = 5'b11110;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    // Bits that must agree with the own address for the current mode.
    function automatic logic [BYTE_W-1:0] care_bits(input logic ten,
                                                    input logic [MASK_W-1:0] m);
        logic [BYTE_W-1:0] c;
        c[7:6] = 2'b11;
        if (ten) begin
            c[5:2] = ~m[4:1];
            c[1:0] = {2{~m[0]}};
        end else begin
            c[5:1] = ~m;
            c[0]   = 1'b0;
        end
        return c;
    endfunction

    function automatic logic masked_eq(input logic [BYTE_W-1:0] a,
                                       input logic [BYTE_W-1:0] b,
                                       input logic [BYTE_W-1:0] care);
        return ((a ^ b) & care) == '0;
    endfunction

    function automatic logic [BYTE_W-1:0] ten_header(input logic [HI_W-1:0] hi);
        return {TEN_TAG, hi, 1'b0};
    endfunction

endpackage

// File: rtl/i2cam_bus_sense.sv
module i2cam_bus_sense
    import i2cam_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
        ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev_o.rise  = scl_i & ~scl_q;
        ev_o.fall  = ~scl_i & scl_q;
    end
endmodule

// File: rtl/i2cam_shift.sv
module i2cam_shift
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              rise_i,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTE_W + 1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
            if (rst) byte_o <= '0;
        end else if (rise_i) begin
            byte_o <= {byte_o[BYTE_W-2:0], sda_i};
            if (cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/i2cam_ctrl.sv
module i2cam_ctrl
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic              ten_bit_i,
    input  logic [HI_W-1:0]   own_hi_i,
    input  logic [BYTE_W-1:0] own_lo_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic [CNT_W-1:0]  bit_cnt_i,
    output logic              clr_o,
    output logic              sda_pull_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] rx_addr_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    phase_e            phase;
    logic              hdr_done;
    logic [BYTE_W-1:0] cap;
    logic              hit;
    logic              byte_end;
    logic              ack_end;

    always_comb begin
        if (ten_bit_i && !hdr_done)
            hit = (rx_byte_i == ten_header(own_hi_i));
        else
            hit = masked_eq(rx_byte_i, own_lo_i, care_bits(ten_bit_i, mask_i));
        byte_end = (phase == ST_RECV) && ev_i.fall && (bit_cnt_i == LAST_BIT);
        ack_end  = (phase == ST_ACK) && ev_i.fall;
        clr_o    = ev_i.start | ack_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= ST_IDLE;
            hdr_done   <= 1'b0;
            cap        <= '0;
            sda_pull_o <= 1'b0;
            irq_o      <= 1'b0;
            rx_addr_o  <= '0;
        end else begin
            irq_o <= 1'b0;
            if (ev_i.stop) begin
                phase      <= ST_IDLE;
                hdr_done   <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (ev_i.start) begin
                phase      <= ST_RECV;
                hdr_done   <= 1'b0;
                sda_pull_o <= 1'b0;
            end else begin
                unique case (phase)
                    ST_RECV: begin
                        if (byte_end) begin
                            if (hit) begin
                                phase      <= ST_ACK;
                                sda_pull_o <= 1'b1;
                                cap        <= rx_byte_i;
                            end else begin
                                phase <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ack_end) begin
                            sda_pull_o <= 1'b0;
                            if (ten_bit_i && !hdr_done) begin
                                hdr_done <= 1'b1;
                                phase    <= ST_RECV;
                            end else begin
                                irq_o     <= 1'b1;
                                rx_addr_o <= cap;
                                phase     <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              ten_bit_i,
    input  logic [HI_W-1:0]   own_hi_i,
    input  logic [BYTE_W-1:0] own_lo_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              sda_pull_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] rx_addr_o
);
    bus_ev_t           ev;
    logic              clr;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  bit_cnt;

    i2cam_bus_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cam_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .rise_i (ev.rise),
        .sda_i  (sda_i),
        .byte_o (rx_byte),
        .cnt_o  (bit_cnt)
    );

    i2cam_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .ten_bit_i  (ten_bit_i),
        .own_hi_i   (own_hi_i),
        .own_lo_i   (own_lo_i),
        .mask_i     (mask_i),
        .rx_byte_i  (rx_byte),
        .bit_cnt_i  (bit_cnt),
        .clr_o      (clr),
        .sda_pull_o (sda_pull_o),
        .irq_o      (irq_o),
        .rx_addr_o  (rx_addr_o)
    );
endmodule

// File: rtl/i2cam_chk.sv
module i2cam_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic       irq_o,
    input logic [7:0] rx_addr_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!sda_pull_o && !irq_o && rx_addr_o == 8'h00));

    // R7
    pull_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !$past(scl_i));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R8
    irq_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $fell(sda_pull_o));

    // R8
    buf_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_addr_o) |-> irq_o);
endmodule

bind i2c_addr_match i2cam_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .irq_o      (irq_o),
    .rx_addr_o  (rx_addr_o)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       ten = 1'b0;
    logic [1:0] own_hi = 2'b00;
    logic [7:0] own_lo = 8'h00;
    logic [4:0] mask = 5'b00000;
    logic       sda_pull;
    logic       irq;
    logic [7:0] rx_addr;
    logic       sda_bus;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    assign sda_bus = sda_drv & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

    i2c_addr_match uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .ten_bit_i  (ten),
        .own_hi_i   (own_hi),
        .own_lo_i   (own_lo),
        .mask_i     (mask),
        .sda_pull_o (sda_pull),
        .irq_o      (irq),
        .rx_addr_o  (rx_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected results, written from the requirements.
    function automatic bit exp7(input logic [7:0] rx, input logic [7:0] own,
                                input logic [4:0] m);
        for (int i = 1; i < 8; i++) begin
            bit dc = (i <= 5) ? m[i-1] : 1'b0;
            if (!dc && rx[i] != own[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit exp10lo(input logic [7:0] rx, input logic [7:0] own,
                                   input logic [4:0] m);
        for (int i = 0; i < 8; i++) begin
            bit dc;
            if (i <= 1) dc = m[0];
            else if (i <= 5) dc = m[i-1];
            else dc = 1'b0;
            if (!dc && rx[i] != own[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit exp10hdr(input logic [7:0] b, input logic [1:0] hi);
        return b[7:3] == 5'b11110 && b[2:1] == hi && b[0] == 1'b0;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; tick(H);
        scl = 1'b1;     tick(H);
        sda_drv = 1'b0; tick(H);
        scl = 1'b0;     tick(H);
    endtask

    task automatic bus_stop;
        scl = 1'b0;     tick(H);
        sda_drv = 1'b0; tick(H);
        scl = 1'b1;     tick(H);
        sda_drv = 1'b1; tick(H);
    endtask

    // Sends eight bits, then clocks the ACK slot and reports the pull seen
    // in the middle of the ninth SCL high phase.
    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0;
            sda_drv = b[i];
            tick(H);
            scl = 1'b1;
            tick(H);
        end
        scl = 1'b0;
        sda_drv = 1'b1;
        tick(H);
        scl = 1'b1;
        tick(1);
        ack = sda_pull;
        tick(H - 1);
        scl = 1'b0;
        tick(2);
    endtask

    task automatic xfer7(input logic [7:0] b, output bit ack);
        bus_start();
        send_byte(b, ack);
        bus_stop();
    endtask

    task automatic xfer10(input logic [7:0] hdr, input logic [7:0] lo,
                          output bit a1, output bit a2, output int irq_after_1);
        int base;
        base = irq_cnt;
        bus_start();
        send_byte(hdr, a1);
        irq_after_1 = irq_cnt - base;
        send_byte(lo, a2);
        bus_stop();
    endtask

    initial begin
        bit a, a1, a2;
        int n, base, i1;
        logic [7:0] b, hdr;
        void'($urandom(32'd20240611));

        tick(5);
        // R1: reset state
        chk(sda_pull == 1'b0 && irq == 1'b0 && rx_addr == 8'h00, "R1 reset",
            {sda_pull, irq, rx_addr}, 0);
        rst = 1'b0;
        tick(1);
        chk(sda_pull == 1'b0 && irq == 1'b0 && rx_addr == 8'h00, "R1 after reset",
            {sda_pull, irq, rx_addr}, 0);

        // R3 / R2 / R8: full 7-bit sweep of the worked case
        ten = 1'b0; own_lo = 8'hA0; mask = 5'b00111;
        n = 0;
        for (int k = 0; k < 128; k++) begin
            b = 8'(k << 1);
            base = irq_cnt;
            xfer7(b, a);
            chk(a == exp7(b, own_lo, mask), "R2 7-bit sweep ack", a, exp7(b, own_lo, mask));
            if (a) begin
                n++;
                chk(irq_cnt - base == 1 && rx_addr == b, "R8 7-bit irq/buffer", rx_addr, b);
                chk(b[0] == 1'b0 && b[7:4] == 4'hA, "R3 acked address in set", b, 8'hA0);
            end else begin
                chk(irq_cnt == base, "R9 no irq on mismatch", irq_cnt - base, 0);
            end
        end
        chk(n == 8, "R3 acked address count", n, 8);

        // R2: R/W bit is not compared
        xfer7(8'hA7, a);
        chk(a == 1'b1 && rx_addr == 8'hA7, "R2 read bit ignored", {a, rx_addr}, 9'h1A7);

        // R7: pull timing on a matching byte
        bus_start();
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; sda_drv = 1'(8'hA2 >> i); tick(H);
            scl = 1'b1; tick(1);
            if (i == 0) chk(sda_pull == 1'b0, "R7 no pull during bit 8", sda_pull, 0);
            tick(H - 1);
        end
        scl = 1'b0; sda_drv = 1'b1; tick(2);
        chk(sda_pull == 1'b1, "R7 pull during scl low before ninth clock", sda_pull, 1);
        tick(H - 2);
        scl = 1'b1; tick(H);
        chk(sda_pull == 1'b1, "R7 pull held through ninth high", sda_pull, 1);
        scl = 1'b0; tick(2);
        chk(sda_pull == 1'b0, "R7 pull released after ninth fall", sda_pull, 0);
        bus_stop();

        // R2: random 7-bit own addresses and masks
        for (int t = 0; t < 60; t++) begin
            own_lo = 8'($urandom);
            mask = 5'($urandom);
            b = (t % 2 == 0) ? (own_lo ^ (8'($urandom) & {2'b00, mask, 1'b1}))
                             : 8'($urandom);
            xfer7(b, a);
            chk(a == exp7(b, own_lo, mask), "R2 random 7-bit", a, exp7(b, own_lo, mask));
        end

        // R9: after a mismatch no later byte is acked before a START
        own_lo = 8'h3C; mask = 5'b00000;
        bus_start();
        send_byte(8'h50, a);
        chk(a == 1'b0, "R9 mismatch no ack", a, 0);
        base = irq_cnt;
        send_byte(8'h3C, a);
        chk(a == 1'b0 && irq_cnt == base, "R9 silent until START", a, 0);
        // R10: repeated START restarts reception
        bus_start();
        send_byte(8'h3C, a);
        chk(a == 1'b1, "R10 repeated START accepted", a, 1);
        bus_stop();
        // R10: after STOP nothing is acked without START
        send_byte(8'h3C, a);
        chk(a == 1'b0, "R10 no ack after STOP", a, 0);
        scl = 1'b1; tick(H); bus_stop();

        // R6 / R5 / R8: 10-bit sweep of the worked case
        ten = 1'b1; own_hi = 2'b01; own_lo = 8'hA0; mask = 5'b00111;
        hdr = {5'b11110, 2'b01, 1'b0};
        n = 0;
        for (int k = 0; k < 256; k++) begin
            b = 8'(k);
            base = irq_cnt;
            xfer10(hdr, b, a1, a2, i1);
            chk(a1 == 1'b1 && i1 == 0, "R8 first 10-bit ack, no irq", {a1, i1[0]}, 2'b10);
            chk(a2 == exp10lo(b, own_lo, mask), "R5 10-bit sweep ack", a2,
                exp10lo(b, own_lo, mask));
            if (a2) begin
                n++;
                chk(b[7:4] == 4'hA && irq_cnt - base == 1 && rx_addr == b,
                    "R6 acked low byte / R8 buffer", rx_addr, b);
            end
        end
        chk(n == 16, "R6 acked low byte count", n, 16);

        // R4: header rules, mask has no effect
        mask = 5'b11111;
        xfer10({5'b11110, 2'b10, 1'b0}, 8'hA0, a1, a2, i1);
        chk(a1 == 1'b0 && a2 == 1'b0, "R4 wrong high bits, mask all ones", {a1, a2}, 0);
        xfer10({5'b11110, 2'b01, 1'b1}, 8'hA0, a1, a2, i1);
        chk(a1 == 1'b0 && a2 == 1'b0, "R4 read bit in header refused", {a1, a2}, 0);
        xfer10({5'b11100, 2'b01, 1'b0}, 8'hA0, a1, a2, i1);
        chk(a1 == 1'b0, "R4 wrong tag refused", a1, 0);
        // R9: header mismatch gives no irq
        base = irq_cnt;
        xfer10(8'h00, 8'hA0, a1, a2, i1);
        chk(irq_cnt == base && a2 == 1'b0, "R9 10-bit header mismatch silent", irq_cnt - base, 0);

        // R4 / R5: random 10-bit cases
        for (int t = 0; t < 40; t++) begin
            own_hi = 2'($urandom);
            own_lo = 8'($urandom);
            mask = 5'($urandom);
            hdr = (t % 4 == 3) ? 8'($urandom) : {5'b11110, own_hi, 1'b0};
            b = (t % 2 == 0) ? (own_lo ^ (8'($urandom) & {2'b00, mask[4:1], {2{mask[0]}}}))
                             : 8'($urandom);
            xfer10(hdr, b, a1, a2, i1);
            chk(a1 == exp10hdr(hdr, own_hi), "R4 random header", a1, exp10hdr(hdr, own_hi));
            chk(a2 == (exp10hdr(hdr, own_hi) && exp10lo(b, own_lo, mask)),
                "R5 random low byte", a2, exp10hdr(hdr, own_hi) && exp10lo(b, own_lo, mask));
        end

        // R10: repeated START in 10-bit mode restarts at the header
        own_hi = 2'b11; own_lo = 8'h5A; mask = 5'b00000;
        bus_start();
        send_byte({5'b11110, 2'b11, 1'b0}, a1);
        bus_start();
        send_byte(8'h5A, a2);
        chk(a1 == 1'b1 && a2 == 1'b0, "R10 restart expects header again", {a1, a2}, 2'b10);
        bus_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule